// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one indivisible memory update at a time on behalf of a processor core. A request names an operation, a byte address, a source operand, a destination register index and a snapshot of the compare-value register. The unit takes a bus lock and reads the addressed location. It then decides whether a store is needed and issues the store if so, all while the lock is held. It then answers with the value that memory held before the update, or with a fault code.

Six operations are offered, each in a 64-bit form and in a 32-bit form:

- exchange
- compare-and-exchange
- fetch-and-add
- fetch-and-add that stores only a non-negative result
- fetch-and-AND
- fetch-and-OR

The 32-bit forms work on one half of a 64-bit memory word, selected by address bit 2, and use byte enables to do so. The values they return and compare are sign-extended to 64 bits.

Destination indices 58 to 62 are network-port registers, which cannot take a result. Index 63 is the hard-wired zero register. A write-back to the zero register is dropped quietly. A write-back to a network-port register turns into an illegal-register fault once the memory update has finished.

Top module: `amo_unit`

## Requirements
- R1: Compare-and-exchange (req_op 1) stores the operand only when the loaded value equals the compare value. In the 32-bit form the compare uses the sign-extended low 32 bits of cmp_val against the sign-extended loaded word. On inequality no write cycle occurs.
- R2: A response without fault to an ordinary register has rsp_wen=1 and carries in rsp_data the memory value from before the update. In the 32-bit forms (req_narrow=1) that value is the addressed word, sign-extended.
- R3: Exchange (req_op 0) always stores the operand and never looks at cmp_val.
- R4: Fetch-and-add (req_op 2) stores old+operand. Fetch-and-AND (req_op 4) stores old&operand. Fetch-and-OR (req_op 5) stores old|operand.
- R5: Fetch-and-add-if-non-negative (req_op 3) computes old+operand. It writes nothing when bit 63 of the sum is set (64-bit form) or when bit 31 of the sum is set (32-bit form).
- R6: A 64-bit request whose address is not a multiple of 8, or a 32-bit request whose address is not a multiple of 4, ends with rsp_fault=1 and rsp_wen=0, and no memory cycle is made.
- R7: An access error (mem_err) on the read ends the operation with rsp_fault=2, rsp_wen=0 and no write. An access error on the write ends it with rsp_fault=2 and rsp_wen=0.
- R8: With destination index 63, the memory update takes place, and the response has rsp_fault=0 and rsp_wen=0.
- R9: With a destination index from 58 to 62, the memory update takes place, and the response has rsp_fault=3 and rsp_wen=0.
- R10: mem_lock is high on every cycle in which mem_req is high, from before the read until after the last write. It is low whenever a response is offered.
- R11: A 32-bit store drives mem_be=0x0F with the data in bits 31:0 when address bit 2 is 0, and mem_be=0xF0 with the data in bits 63:32 when it is 1. A 64-bit store drives mem_be=0xFF. mem_addr is always the 8-byte-aligned address.
- R12: req_ready is high only while the unit is idle. A response stays valid and unchanged until rsp_ready accepts it, and no new request is taken before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request taken on this edge |
| req_op | input | 3 | Operation: 0 xchg, 1 cas, 2 add, 3 add-if-non-negative, 4 and, 5 or (6, 7 read only) |
| req_narrow | input | 1 | 1 selects the 32-bit form |
| req_addr | input | ADDR_W | Byte address |
| req_opnd | input | 64 | Source operand |
| req_dst | input | IDX_W | Destination register index |
| cmp_val | input | 64 | Compare-value register contents |
| mem_req | output | 1 | Memory cycle request, held until mem_ack |
| mem_we | output | 1 | 1 for write cycle |
| mem_lock | output | 1 | Bus lock over the read-modify-write sequence |
| mem_addr | output | ADDR_W | 8-byte-aligned word address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables of the write |
| mem_ack | input | 1 | Memory cycle complete |
| mem_err | input | 1 | Access error, valid with mem_ack |
| mem_rdata | input | 64 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response accepted |
| rsp_wen | output | 1 | Write rsp_data to register rsp_dst |
| rsp_dst | output | IDX_W | Destination register index |
| rsp_data | output | 64 | Old memory value |
| rsp_fault | output | 2 | 0 none, 1 unaligned, 2 access error, 3 illegal register |

## Verification
Two things can happen in the same cycle: a finished response held back by rsp_ready, and the next request already waiting at the input. The bench provokes this by holding rsp_ready low for ten cycles after an OR update, with req_valid kept high. While the response waits, it checks three things: the response stays offered, req_ready stays low, and the lock has already been released. It also checks that the waiting request causes no memory cycle. A scoreboard then matches the response, the number of memory cycles and the whole memory image against a model of the requirements.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int XLEN = 64;

  typedef enum logic [2:0] {
    OP_XCHG  = 3'd0,
    OP_CAS   = 3'd1,
    OP_ADD   = 3'd2,
    OP_ADDNN = 3'd3,
    OP_AND   = 3'd4,
    OP_OR    = 3'd5
  } amo_op_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ALIGN  = 2'd1,
    FLT_ACCESS = 2'd2,
    FLT_REG    = 2'd3
  } amo_flt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_READ, ST_CALC, ST_WRITE, ST_DONE
  } amo_st_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_op_e              op,
  input  logic                 narrow,
  input  logic [XLEN-1:0]      old_val,
  input  logic [XLEN-1:0]      opnd,
  input  logic [XLEN-1:0]      cmp_val,
  output logic [XLEN-1:0]      new_val,
  output logic                 store_en
);
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] sum;
  logic [XLEN-1:0] cmp_ext;
  logic            sum_neg;

  always_comb begin
    sum     = old_val + opnd;
    cmp_ext = narrow ? {{HW{cmp_val[HW-1]}}, cmp_val[HW-1:0]} : cmp_val;
    sum_neg = narrow ? sum[HW-1] : sum[XLEN-1];
    new_val  = old_val;
    store_en = 1'b0;
    case (op)
      OP_XCHG:  begin new_val = opnd;           store_en = 1'b1;                end
      OP_CAS:   begin new_val = opnd;           store_en = (old_val == cmp_ext); end
      OP_ADD:   begin new_val = sum;            store_en = 1'b1;                end
      OP_ADDNN: begin new_val = sum;            store_en = !sum_neg;            end
      OP_AND:   begin new_val = old_val & opnd; store_en = 1'b1;                end
      OP_OR:    begin new_val = old_val | opnd; store_en = 1'b1;                end
      default:  begin new_val = old_val;        store_en = 1'b0;                end
    endcase
  end
endmodule

// File: rtl/amo_dst_check.sv
module amo_dst_check #(
  parameter int IDX_W    = 6,
  parameter int ZERO_IDX = 63,
  parameter int NET_LO   = 58,
  parameter int NET_HI   = 62
) (
  input  logic [IDX_W-1:0] dst,
  output logic             is_zero,
  output logic             is_net
);
  assign is_zero = (dst == IDX_W'(ZERO_IDX));
  assign is_net  = (dst >= IDX_W'(NET_LO)) && (dst <= IDX_W'(NET_HI));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int IDX_W    = 6,
  parameter int ZERO_IDX = 63,
  parameter int NET_LO   = 58,
  parameter int NET_HI   = 62
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_op,
  input  logic                 req_narrow,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_opnd,
  input  logic [IDX_W-1:0]     req_dst,
  input  logic [63:0]          cmp_val,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic                 mem_lock,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [63:0]          mem_wdata,
  output logic [7:0]           mem_be,
  input  logic                 mem_ack,
  input  logic                 mem_err,
  input  logic [63:0]          mem_rdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_wen,
  output logic [IDX_W-1:0]     rsp_dst,
  output logic [63:0]          rsp_data,
  output logic [1:0]           rsp_fault
);
  localparam int BE_W  = XLEN / 8;
  localparam int OFF_W = $clog2(BE_W);
  localparam int HW    = XLEN / 2;
  localparam int HB    = BE_W / 2;

  amo_st_e           state;
  amo_op_e           op_q;
  logic              narrow_q;
  logic [ADDR_W-1:0] addr_q;
  logic [XLEN-1:0]   opnd_q, cmp_q, old_q, new_q;
  logic [IDX_W-1:0]  dst_q;
  amo_flt_e          fault_q;
  logic              wen_q;

  logic [XLEN-1:0]   alu_new;
  logic              alu_store;
  logic              dst_zero, dst_net;
  logic              misal;
  logic [HW-1:0]     rd_half;
  logic [XLEN-1:0]   rd_ext;
  amo_flt_e          fin_fault;
  logic              fin_wen;

  amo_alu u_alu (
    .op(op_q), .narrow(narrow_q), .old_val(old_q), .opnd(opnd_q),
    .cmp_val(cmp_q), .new_val(alu_new), .store_en(alu_store)
  );

  amo_dst_check #(.IDX_W(IDX_W), .ZERO_IDX(ZERO_IDX), .NET_LO(NET_LO), .NET_HI(NET_HI)) u_dst (
    .dst(dst_q), .is_zero(dst_zero), .is_net(dst_net)
  );

  always_comb begin
    misal     = narrow_q ? (addr_q[1:0] != 2'b00) : (addr_q[OFF_W-1:0] != '0);
    rd_half   = addr_q[OFF_W-1] ? mem_rdata[XLEN-1:HW] : mem_rdata[HW-1:0];
    rd_ext    = narrow_q ? {{HW{rd_half[HW-1]}}, rd_half} : mem_rdata;
    fin_fault = dst_net ? FLT_REG : FLT_NONE;
    fin_wen   = !dst_zero && !dst_net;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      op_q     <= OP_XCHG;
      narrow_q <= 1'b0;
      addr_q   <= '0;
      opnd_q   <= '0;
      cmp_q    <= '0;
      old_q    <= '0;
      new_q    <= '0;
      dst_q    <= '0;
      fault_q  <= FLT_NONE;
      wen_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          op_q     <= amo_op_e'(req_op);
          narrow_q <= req_narrow;
          addr_q   <= req_addr;
          opnd_q   <= req_opnd;
          cmp_q    <= cmp_val;
          dst_q    <= req_dst;
          old_q    <= '0;
          state    <= ST_LOCK;
        end
        ST_LOCK: if (misal) begin
          fault_q <= FLT_ALIGN;
          wen_q   <= 1'b0;
          state   <= ST_DONE;
        end else begin
          state <= ST_READ;
        end
        ST_READ: if (mem_ack) begin
          if (mem_err) begin
            fault_q <= FLT_ACCESS;
            wen_q   <= 1'b0;
            state   <= ST_DONE;
          end else begin
            old_q <= rd_ext;
            state <= ST_CALC;
          end
        end
        ST_CALC: begin
          new_q <= alu_new;
          if (alu_store) begin
            state <= ST_WRITE;
          end else begin
            fault_q <= fin_fault;
            wen_q   <= fin_wen;
            state   <= ST_DONE;
          end
        end
        ST_WRITE: if (mem_ack) begin
          fault_q <= mem_err ? FLT_ACCESS : fin_fault;
          wen_q   <= mem_err ? 1'b0 : fin_wen;
          state   <= ST_DONE;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign mem_req   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_lock  = (state == ST_LOCK) || (state == ST_READ) ||
                     (state == ST_CALC) || (state == ST_WRITE);
  assign mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = narrow_q ? {2{new_q[HW-1:0]}} : new_q;
  assign mem_be    = narrow_q ? (addr_q[OFF_W-1] ? {{HB{1'b1}}, {HB{1'b0}}}
                                                 : {{HB{1'b0}}, {HB{1'b1}}})
                              : {BE_W{1'b1}};
  assign rsp_valid = (state == ST_DONE);
  assign rsp_wen   = wen_q;
  assign rsp_dst   = dst_q;
  assign rsp_data  = old_q;
  assign rsp_fault = fault_q;

  AST_CAS_STORE_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && op_q == OP_CAS) |->
      (narrow_q ? (old_q[HW-1:0] == cmp_q[HW-1:0]) : (old_q == cmp_q))); // R1
  AST_ADDNN_NONNEG_STORE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && op_q == OP_ADDNN) |->
      !(narrow_q ? new_q[HW-1] : new_q[XLEN-1])); // R5
  AST_ALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && misal) |=> !mem_req); // R6
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != FLT_NONE) |-> !rsp_wen); // R7
  AST_ZERO_DROP: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_dst == IDX_W'(ZERO_IDX)) |-> !rsp_wen); // R8
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_lock); // R10
  AST_LOCK_FREED: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_lock); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_fault))); // R12
endmodule

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic        req_narrow = 1'b0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_opnd = '0;
  logic [5:0]  req_dst = '0;
  logic [63:0] cmp_val = '0;
  logic        mem_req, mem_we, mem_lock;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic        mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_wen;
  logic [5:0]  rsp_dst;
  logic [63:0] rsp_data;
  logic [1:0]  rsp_fault;

  always #4 clk = ~clk;

  amo_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_narrow(req_narrow), .req_addr(req_addr),
    .req_opnd(req_opnd), .req_dst(req_dst), .cmp_val(cmp_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_wen(rsp_wen), .rsp_dst(rsp_dst), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
  );

  int checks = 0;
  int errors = 0;
  int acc_cnt = 0;
  logic [15:0] rd_err_addr = 16'hFFFF;
  logic [15:0] wr_err_addr = 16'hFFFF;
  logic [63:0] mem [16];
  logic [63:0] shadow [16];

  typedef struct {
    logic [63:0] data;
    logic        wen;
    logic [1:0]  flt;
    int          acc;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // external memory: answers one cycle after a request, away from the rising edge
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      acc_cnt++;
      if (!mem_lock) chk(1'b0, "R10", "request without lock", 0, 1);
      if (!mem_we) begin
        mem_err   = (mem_addr == rd_err_addr);
        mem_rdata = mem[mem_addr[6:3]];
      end else begin
        mem_err = (mem_addr == wr_err_addr);
        if (!mem_err)
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[6:3]][8*b +: 8] = mem_wdata[8*b +: 8];
      end
    end else begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  task automatic ref_op(input logic [2:0] op, input bit narrow, input logic [15:0] addr,
                        input logic [63:0] opnd, input logic [5:0] dst,
                        input logic [63:0] cmp, input string tag, output exp_t e);
    logic [15:0] al;
    logic [31:0] half;
    logic [63:0] old, nv, sum, cx;
    bit st;
    e.tag = tag; e.wen = 0; e.data = '0; e.flt = 2'd0; e.acc = 0;
    if (narrow ? (addr[1:0] != 0) : (addr[2:0] != 0)) begin e.flt = 2'd1; return; end
    e.acc = 1;
    al = {addr[15:3], 3'b000};
    if (al == rd_err_addr) begin e.flt = 2'd2; return; end
    half = addr[2] ? shadow[addr[6:3]][63:32] : shadow[addr[6:3]][31:0];
    old  = narrow ? {{32{half[31]}}, half} : shadow[addr[6:3]];
    sum  = old + opnd;
    cx   = narrow ? {{32{cmp[31]}}, cmp[31:0]} : cmp;
    case (op)
      3'd0: begin nv = opnd; st = 1; end
      3'd1: begin nv = opnd; st = (old == cx); end
      3'd2: begin nv = sum; st = 1; end
      3'd3: begin nv = sum; st = narrow ? !sum[31] : !sum[63]; end
      3'd4: begin nv = old & opnd; st = 1; end
      3'd5: begin nv = old | opnd; st = 1; end
      default: begin nv = old; st = 0; end
    endcase
    if (st) begin
      e.acc = 2;
      if (al == wr_err_addr) begin e.flt = 2'd2; return; end
      if (!narrow) shadow[addr[6:3]] = nv;
      else if (addr[2]) shadow[addr[6:3]][63:32] = nv[31:0];
      else shadow[addr[6:3]][31:0] = nv[31:0];
    end
    if (dst == 6'd63) e.flt = 2'd0;
    else if (dst >= 6'd58 && dst <= 6'd62) e.flt = 2'd3;
    else begin e.wen = 1; e.data = old; end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_valid && rsp_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R12", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          int bad;
          e = sb.pop_front();
          chk(rsp_fault == e.flt, e.tag, "fault", rsp_fault, e.flt);
          chk(rsp_wen == e.wen, e.tag, "wen", rsp_wen, e.wen);
          if (e.wen) chk(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
          chk(acc_cnt == e.acc, e.tag, "memory cycles", acc_cnt, e.acc);
          bad = -1;
          for (int i = 0; i < 16; i++) if (mem[i] !== shadow[i] && bad < 0) bad = i;
          if (bad >= 0) chk(1'b0, e.tag, "memory image", mem[bad], shadow[bad]);
          else chk(1'b1, e.tag, "memory image", 0, 0);
        end
        acc_cnt = 0;
      end
    end
  end

  task automatic do_op(input logic [2:0] op, input bit narrow, input logic [15:0] addr,
                       input logic [63:0] opnd, input logic [5:0] dst,
                       input logic [63:0] cmp, input string tag, input int hold);
    exp_t e;
    ref_op(op, narrow, addr, opnd, dst, cmp, tag, e);
    sb.push_back(e);
    @(negedge clk);
    if (hold > 0) rsp_ready = 1'b0;
    req_op = op; req_narrow = narrow; req_addr = addr; req_opnd = opnd;
    req_dst = dst; cmp_val = cmp; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (hold > 0) begin
      while (!rsp_valid) @(negedge clk);
      acc_cnt = acc_cnt + 100;
      repeat (hold) @(negedge clk);
      chk(rsp_valid == 1'b1, "R12", "response held", rsp_valid, 1);
      chk(req_ready == 1'b0, "R12", "second request refused", req_ready, 0);
      chk(mem_lock == 1'b0, "R10", "lock freed while waiting", mem_lock, 0);
      chk(acc_cnt == e.acc + 100, "R12", "no cycle for waiting request", acc_cnt, e.acc + 100);
      acc_cnt = acc_cnt - 100;
      @(posedge clk);
      #2;
      rsp_ready = 1'b1;
      req_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    chk(1'b0, "watchdog", "timeout", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mem[0] = 64'h0000_0000_0000_0005;
    mem[1] = 64'h1234_5678_9ABC_DEF0;
    mem[2] = 64'hFFFF_FFFF_FFFF_FFF0;
    mem[3] = 64'h8000_0001_7FFF_FFFE;
    for (int i = 4; i < 16; i++) mem[i] = 64'(i) * 64'h0101_0101_0101_0101;
    for (int i = 0; i < 16; i++) shadow[i] = mem[i];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "reset ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R12", "reset rsp_valid", rsp_valid, 0);
    chk(mem_lock == 1'b0, "R10", "reset lock", mem_lock, 0);
    chk(mem_req == 1'b0, "R10", "reset mem_req", mem_req, 0);

    do_op(3'd0, 0, 16'h0008, 64'hCAFE_F00D_1122_3344, 6'd5, 64'h0, "R3 R2 xchg64", 0);
    do_op(3'd0, 1, 16'h001C, 64'hDEAD_BEEF_0000_0042, 6'd6, 64'h0, "R11 R2 xchg32 upper", 0);
    do_op(3'd1, 0, 16'h0000, 64'h77, 6'd7, 64'h5, "R1 cas64 match", 0);
    do_op(3'd1, 0, 16'h0000, 64'h99, 6'd7, 64'h5, "R1 cas64 mismatch", 0);
    do_op(3'd1, 1, 16'h0018, 64'hAAAA_AAAA_0000_1234, 6'd8, 64'h1111_2222_7FFF_FFFE, "R1 cas32 match", 0);
    do_op(3'd2, 0, 16'h0020, 64'h3, 6'd9, 64'h0, "R4 add64", 0);
    do_op(3'd4, 1, 16'h0028, 64'h0F0F_0F0F_00FF_00F0, 6'd10, 64'h0, "R4 R11 and32 lower", 0);
    do_op(3'd5, 0, 16'h0030, 64'h8000_0000_0000_0001, 6'd11, 64'h0, "R4 or64", 0);
    do_op(3'd3, 0, 16'h0010, 64'd20, 6'd12, 64'h0, "R5 addnn64 store", 0);
    do_op(3'd3, 0, 16'h0010, -64'sd10, 6'd12, 64'h0, "R5 addnn64 suppress", 0);
    do_op(3'd3, 1, 16'h001C, 64'h7FFF_FFF0, 6'd13, 64'h0, "R5 addnn32 bit31", 0);
    do_op(3'd0, 0, 16'h0024, 64'h1, 6'd14, 64'h0, "R6 misaligned64", 0);
    do_op(3'd0, 1, 16'h0024, 64'h5555_5555_ABCD_0001, 6'd14, 64'h0, "R6 aligned32", 0);
    do_op(3'd0, 1, 16'h0026, 64'h1, 6'd14, 64'h0, "R6 misaligned32", 0);
    rd_err_addr = 16'h0038;
    do_op(3'd0, 0, 16'h0038, 64'h1, 6'd15, 64'h0, "R7 read error", 0);
    rd_err_addr = 16'hFFFF;
    wr_err_addr = 16'h0038;
    do_op(3'd0, 0, 16'h0038, 64'h1, 6'd15, 64'h0, "R7 write error", 0);
    wr_err_addr = 16'hFFFF;
    do_op(3'd0, 0, 16'h0008, 64'h0BAD_0BAD_0BAD_0BAD, 6'd63, 64'h0, "R8 zero register", 0);
    do_op(3'd2, 0, 16'h0040, 64'h10, 6'd60, 64'h0, "R9 network register", 0);
    do_op(3'd5, 0, 16'h0048, 64'hF0, 6'd16, 64'h0, "R12 R10 back-pressure", 10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule